// File: doc/BRIEF.md
# Flash Command Register Sequencer

This block is the software-triggered instruction engine of an octal/quad serial flash controller. Software uses a 32-bit register bus to stage an instruction in six command words. Writing the lowest word launches the staged instruction. The block decodes the staged fields into a phase descriptor and hands it to a downstream serializer over a valid/ready pair. It then waits for the serializer's completion pulse and records the outcome in a command status word.

An instruction comes in one of three kinds:

- A command/address instruction with no data.
- A command/address instruction that expects a data phase.
- A data-sequence descriptor, which supplies the data phase for the instruction before it.

The block validates the sequence and the work mode before it launches anything. A malformed request is rejected at once: it completes with failure status and never reaches the serializer. Software polls a busy flag and the status word, or uses the done pulse it requests per launch.

Top module: `flash_instr_seq`

## Requirements
- R1: After reset, busy (controller word 0x100, bit 7) is 0, the status word (0x44) is 0, the work-mode field is 0 and no phase is offered.
- R2: Command words sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, and each reads back what was last written to it. Writes to 0x04–0x14 launch nothing.
- R3: The work-mode field is config word 0x230, bits [6:5]. Only value 1 permits instructions. A launch under any other mode completes immediately with status 0xC001 (completed, failed, invalid sequence) and offers no phase.
- R4: A launch of type 0 or type 1 offers a command phase (kind 0) with these fields:
  - type: word1[6:0]
  - opcode: word3[23:16]
  - address-byte count: word3[30:28]
  - address: byte 0 from word1[31:24], bytes 1–4 from word2 bytes low to high, byte 5 from word3[7:0]
  - command lanes (log2): word4[9:8]
  - address lanes (log2): word4[1:0]
  - bank: word4[14:12]
- R5: An offered phase and its fields stay constant until the serializer accepts it.
- R6: A type-0 instruction completes when the serializer reports done without error. Status then reads 0x8000 and busy clears.
- R7: After its command phase finishes, a type-1 instruction stays busy and offers nothing. A following type-127 launch offers a data phase (kind 1) with these fields:
  - byte count: low half from word2[31:16], high half from word3[15:0]
  - dummy cycles: word3[25:20]
  - direction: word4[4], where 1 means write to flash
  - data lanes (log2): word4[9:8]
  - bank: word4[14:12]
- R8: When the data phase completes without error, status reads 0x8000. done_o pulses for one cycle at completion when bit 0 of the launching write was 1, and not when it was 0.
- R9: Each of the following completes at once with status 0xC001, leaves busy clear and offers no phase:
  - a type-127 launch that no type-1 instruction precedes
  - an undefined type
  - any type other than 127 while a type-1 instruction is awaiting its descriptor
- R10: A serializer error {dqs, crc, bus} reported with done completes the instruction with status bit 15, bit 14 and bits 3:1 equal to that error vector.
- R11: A launch write while a phase is in flight is ignored; the phase in flight is unchanged.
- R12: An accepted launch clears the status word, which reads 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| ph_valid_o | output | 1 | Phase descriptor offered |
| ph_ready_i | input | 1 | Serializer accepts phase |
| ph_kind_o | output | 1 | 0 command/address phase, 1 data phase |
| ph_opcode_o | output | 8 | Command opcode |
| ph_addr_o | output | 48 | Address, byte 0 in bits 7:0 |
| ph_addr_nbytes_o | output | 3 | Address byte count |
| ph_cmd_lanes_o | output | 2 | log2 of command lanes |
| ph_addr_lanes_o | output | 2 | log2 of address lanes |
| ph_bank_o | output | 3 | Target bank |
| ph_count_o | output | 32 | Data byte count |
| ph_dummy_o | output | 6 | Dummy cycles |
| ph_dir_o | output | 1 | 1 write to flash, 0 read |
| ph_data_lanes_o | output | 2 | log2 of data lanes |
| srl_done_i | input | 1 | Serializer finished the accepted phase |
| srl_err_i | input | 3 | {dqs, crc, bus} error flags with done |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Requested completion pulse |

## Verification
Register readback is combinational, so it is due in the same cycle as the address. The outcome of a launch is due right after the clock edge that registers the launching write: an offered phase, a busy flag, or an immediate rejection status. Acceptance by the serializer drops the offer one edge after ready is seen. Completion status and the done pulse appear one edge after the serializer's done. The bench drives every input on the falling edge and reads outputs one falling edge (or 1 ns after a rising edge) later, so each check lands exactly on the cycle where its result becomes due.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned NUM_CMD_REGS = 6;
  localparam int unsigned BUS_AW       = 12;
  localparam int unsigned ADDR_BYTES   = 6;
  localparam int unsigned STAT_W       = 16;

  localparam logic [BUS_AW-1:0] OFS_STATUS = 12'h044;
  localparam logic [BUS_AW-1:0] OFS_CTRL   = 12'h100;
  localparam logic [BUS_AW-1:0] OFS_CONFIG = 12'h230;

  localparam logic [6:0] TYPE_CMD      = 7'd0;
  localparam logic [6:0] TYPE_CMD_DATA = 7'd1;
  localparam logic [6:0] TYPE_DSEQ     = 7'd127;
  localparam logic [1:0] MODE_INSTR    = 2'd1;

  localparam logic [STAT_W-1:0] STAT_OK     = 16'h8000;
  localparam logic [STAT_W-1:0] STAT_REJECT = 16'hC001;

  typedef struct packed {
    logic [7:0]              opcode;
    logic [8*ADDR_BYTES-1:0] addr;
    logic [2:0]              addr_nbytes;
    logic [1:0]              cmd_lanes;
    logic [1:0]              addr_lanes;
    logic [2:0]              bank;
  } cmd_desc_t;

  typedef struct packed {
    logic [31:0] count;
    logic [5:0]  dummy;
    logic        dir;
    logic [1:0]  data_lanes;
    logic [2:0]  bank;
  } data_desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD_ISSUE, S_CMD_WAIT, S_ARMED, S_DATA_ISSUE, S_DATA_WAIT
  } seq_state_e;
endpackage

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_seq_pkg::*;
#(
  parameter int unsigned NUM_REGS = NUM_CMD_REGS,
  parameter int unsigned DW       = REG_W,
  parameter int unsigned AW       = BUS_AW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [NUM_REGS-1:0][DW-1:0]   regs_o,
  output logic [1:0]                    mode_o
);
  localparam int unsigned STRIDE = DW / 8;

  logic [NUM_REGS-1:0][DW-1:0] regs_q;
  logic [1:0]                  mode_q;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    localparam logic [AW-1:0] OFS = AW'(gi * STRIDE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    regs_q[gi] <= '0;
      else if (wr_i && addr_i == OFS) regs_q[gi] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mode_q <= '0;
    else if (wr_i && addr_i == OFS_CONFIG) mode_q <= wdata_i[6:5];
  end

  assign regs_o = regs_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/flash_instr_decode.sv
module flash_instr_decode
  import flash_seq_pkg::*;
#(
  parameter int unsigned NUM_REGS = NUM_CMD_REGS,
  parameter int unsigned DW       = REG_W
) (
  input  logic [NUM_REGS-1:0][DW-1:0] regs_i,
  output logic [6:0]                  instr_type_o,
  output cmd_desc_t                   cmd_o,
  output data_desc_t                  data_o
);
  logic [DW-1:0] w1, w2, w3, w4;
  assign w1 = regs_i[1];
  assign w2 = regs_i[2];
  assign w3 = regs_i[3];
  assign w4 = regs_i[4];

  assign instr_type_o = w1[6:0];

  always_comb begin
    cmd_o.opcode      = w3[23:16];
    cmd_o.addr        = {w3[7:0], w2[31:24], w2[23:16], w2[15:8], w2[7:0], w1[31:24]};
    cmd_o.addr_nbytes = w3[30:28];
    cmd_o.cmd_lanes   = w4[9:8];
    cmd_o.addr_lanes  = w4[1:0];
    cmd_o.bank        = w4[14:12];
  end

  always_comb begin
    data_o.count      = {w3[15:0], w2[31:16]};
    data_o.dummy      = w3[25:20];
    data_o.dir        = w4[4];
    data_o.data_lanes = w4[9:8];
    data_o.bank       = w4[14:12];
  end

  logic unused_bits;
  assign unused_bits = ^{regs_i[0], regs_i[NUM_REGS-1:5], w1[23:7], w3[31], w3[27:26],
                         w4[31:15], w4[11:10], w4[7:5], w4[3:2]};
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              done_bit_i,
  input  logic              mode_ok_i,
  input  logic [6:0]        instr_type_i,
  input  cmd_desc_t         cmd_i,
  input  data_desc_t        data_i,
  input  logic              ph_ready_i,
  input  logic              srl_done_i,
  input  logic [2:0]        srl_err_i,
  output logic              ph_valid_o,
  output logic              ph_kind_o,
  output cmd_desc_t         cmd_o,
  output data_desc_t        data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [STAT_W-1:0] status_o
);
  seq_state_e        state_q;
  cmd_desc_t         cmd_q;
  data_desc_t        data_q;
  logic              has_data_q, done_req_q, done_q;
  logic [STAT_W-1:0] status_q;
  logic              first_ok;

  assign first_ok = mode_ok_i && (instr_type_i == TYPE_CMD || instr_type_i == TYPE_CMD_DATA);

  function automatic logic [STAT_W-1:0] end_status(input logic [2:0] err);
    return {1'b1, |err, 10'b0, err, 1'b0};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cmd_q      <= '0;
      data_q     <= '0;
      has_data_q <= 1'b0;
      done_req_q <= 1'b0;
      done_q     <= 1'b0;
      status_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (launch_i) begin
          if (first_ok) begin
            status_q   <= '0;
            cmd_q      <= cmd_i;
            has_data_q <= (instr_type_i == TYPE_CMD_DATA);
            done_req_q <= done_bit_i;
            state_q    <= S_CMD_ISSUE;
          end else begin
            status_q <= STAT_REJECT;
            done_q   <= done_bit_i;
          end
        end
        S_CMD_ISSUE: if (ph_ready_i) state_q <= S_CMD_WAIT;
        S_CMD_WAIT: if (srl_done_i) begin
          if (has_data_q && srl_err_i == '0) begin
            state_q <= S_ARMED;
          end else begin
            status_q <= end_status(srl_err_i);
            done_q   <= done_req_q;
            state_q  <= S_IDLE;
          end
        end
        S_ARMED: if (launch_i) begin
          if (mode_ok_i && instr_type_i == TYPE_DSEQ) begin
            data_q     <= data_i;
            done_req_q <= done_bit_i;
            state_q    <= S_DATA_ISSUE;
          end else begin
            status_q <= STAT_REJECT;
            done_q   <= done_bit_i;
            state_q  <= S_IDLE;
          end
        end
        S_DATA_ISSUE: if (ph_ready_i) state_q <= S_DATA_WAIT;
        S_DATA_WAIT: if (srl_done_i) begin
          status_q <= end_status(srl_err_i);
          done_q   <= done_req_q;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ph_valid_o = (state_q == S_CMD_ISSUE) || (state_q == S_DATA_ISSUE);
  assign ph_kind_o  = (state_q == S_DATA_ISSUE);
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign cmd_o      = cmd_q;
  assign data_o     = data_q;

  // R5
  ph_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_valid_o && !ph_ready_i |=> ph_valid_o && $stable(ph_kind_o) && $stable(cmd_o) && $stable(data_o));
  // R12
  busy_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !status_o[15]);
  // R9
  reject_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> !busy_o && !ph_valid_o);
  // R8
  done_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o[15]);
  // R11
  ph_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_valid_o |-> busy_o);
endmodule

// File: rtl/flash_instr_seq.sv
module flash_instr_seq
  import flash_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic [11:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        ph_valid_o,
  input  logic        ph_ready_i,
  output logic        ph_kind_o,
  output logic [7:0]  ph_opcode_o,
  output logic [47:0] ph_addr_o,
  output logic [2:0]  ph_addr_nbytes_o,
  output logic [1:0]  ph_cmd_lanes_o,
  output logic [1:0]  ph_addr_lanes_o,
  output logic [2:0]  ph_bank_o,
  output logic [31:0] ph_count_o,
  output logic [5:0]  ph_dummy_o,
  output logic        ph_dir_o,
  output logic [1:0]  ph_data_lanes_o,
  input  logic        srl_done_i,
  input  logic [2:0]  srl_err_i,
  output logic        busy_o,
  output logic        done_o
);
  localparam logic [BUS_AW-1:0] REGS_END = BUS_AW'(NUM_CMD_REGS * 4);

  logic [NUM_CMD_REGS-1:0][REG_W-1:0] regs;
  logic [1:0]        mode;
  logic [6:0]        instr_type;
  cmd_desc_t         cmd_dec, cmd_ph;
  data_desc_t        data_dec, data_ph;
  logic [STAT_W-1:0] status;
  logic              launch;

  assign launch = bus_wr_i && (bus_addr_i == '0);

  flash_cmd_regs #(.NUM_REGS(NUM_CMD_REGS), .DW(REG_W), .AW(BUS_AW)) i_regs (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .regs_o(regs), .mode_o(mode)
  );

  flash_instr_decode #(.NUM_REGS(NUM_CMD_REGS), .DW(REG_W)) i_decode (
    .regs_i(regs), .instr_type_o(instr_type), .cmd_o(cmd_dec), .data_o(data_dec)
  );

  flash_seq_fsm i_fsm (
    .clk_i, .rst_ni, .launch_i(launch), .done_bit_i(bus_wdata_i[0]),
    .mode_ok_i(mode == MODE_INSTR), .instr_type_i(instr_type),
    .cmd_i(cmd_dec), .data_i(data_dec), .ph_ready_i, .srl_done_i, .srl_err_i,
    .ph_valid_o, .ph_kind_o, .cmd_o(cmd_ph), .data_o(data_ph),
    .busy_o, .done_o, .status_o(status)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i < REGS_END && bus_addr_i[1:0] == 2'b00)
      bus_rdata_o = regs[bus_addr_i[4:2]];
    else if (bus_addr_i == OFS_STATUS)
      bus_rdata_o = {{(REG_W-STAT_W){1'b0}}, status};
    else if (bus_addr_i == OFS_CTRL)
      bus_rdata_o = {24'b0, busy_o, 7'b0};
    else if (bus_addr_i == OFS_CONFIG)
      bus_rdata_o = {25'b0, mode, 5'b0};
  end

  assign ph_opcode_o      = cmd_ph.opcode;
  assign ph_addr_o        = cmd_ph.addr;
  assign ph_addr_nbytes_o = cmd_ph.addr_nbytes;
  assign ph_cmd_lanes_o   = cmd_ph.cmd_lanes;
  assign ph_addr_lanes_o  = cmd_ph.addr_lanes;
  assign ph_bank_o        = ph_kind_o ? data_ph.bank : cmd_ph.bank;
  assign ph_count_o       = data_ph.count;
  assign ph_dummy_o       = data_ph.dummy;
  assign ph_dir_o         = data_ph.dir;
  assign ph_data_lanes_o  = data_ph.data_lanes;

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(launch));
endmodule

// File: tb/test_flash_instr_seq.sv
module test_flash_instr_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ph_valid, ph_ready = 1'b0, ph_kind;
  logic [7:0]  ph_opcode;
  logic [47:0] ph_addr;
  logic [2:0]  ph_nb, ph_bank;
  logic [1:0]  ph_cl, ph_al, ph_dl;
  logic [31:0] ph_count;
  logic [5:0]  ph_dummy;
  logic        ph_dir, srl_done = 1'b0;
  logic [2:0]  srl_err = '0;
  logic        busy, done;
  int checks = 0, errors = 0;
  logic        done_seen;
  logic [31:0] rv;

  always #4 clk = ~clk;

  flash_instr_seq i_flash_instr_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .ph_valid_o(ph_valid),
    .ph_ready_i(ph_ready), .ph_kind_o(ph_kind), .ph_opcode_o(ph_opcode),
    .ph_addr_o(ph_addr), .ph_addr_nbytes_o(ph_nb), .ph_cmd_lanes_o(ph_cl),
    .ph_addr_lanes_o(ph_al), .ph_bank_o(ph_bank), .ph_count_o(ph_count),
    .ph_dummy_o(ph_dummy), .ph_dir_o(ph_dir), .ph_data_lanes_o(ph_dl),
    .srl_done_i(srl_done), .srl_err_i(srl_err), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = '0;
  endtask

  task automatic accept();
    ph_ready = 1'b1; @(negedge clk); ph_ready = 1'b0;
  endtask

  task automatic finish_phase(input logic [2:0] err);
    srl_err = err; srl_done = 1'b1;
    @(posedge clk); #1; done_seen = done;
    @(negedge clk); srl_done = 1'b0; srl_err = '0;
  endtask

  task automatic t_reset();
    rd(12'h100, rv); chk("R1 busy", rv, 0);
    rd(12'h044, rv); chk("R1 status", rv, 0);
    rd(12'h230, rv); chk("R1 mode", rv, 0);
    chk("R1 ph_valid", ph_valid, 0);
  endtask

  task automatic t_staging();
    wr(12'h014, 32'hCAFE0005); wr(12'h010, 32'h00003201);
    wr(12'h00C, 32'h509F0055); wr(12'h008, 32'h44332211); wr(12'h004, 32'hA0000000);
    rd(12'h014, rv); chk("R2 word5", rv, 32'hCAFE0005);
    rd(12'h00C, rv); chk("R2 word3", rv, 32'h509F0055);
    chk("R2 no launch", {busy, ph_valid}, 0);
  endtask

  task automatic t_mode_reject();
    wr(12'h000, 32'h0);
    rd(12'h044, rv); chk("R3 reject status", rv, 32'hC001);
    chk("R3 no phase", {busy, ph_valid}, 0);
    wr(12'h230, 32'h20);
    rd(12'h230, rv); chk("R3 mode readback", rv, 32'h20);
  endtask

  task automatic t_type0();
    wr(12'h000, 32'h1);
    chk("R4 valid", ph_valid, 1);
    chk("R4 kind", ph_kind, 0);
    chk("R4 opcode", ph_opcode, 8'h9F);
    chk("R4 addr", ph_addr, 48'h55_4433_2211_A0);
    chk("R4 lanes/nbytes/bank", {ph_nb, ph_cl, ph_al, ph_bank}, {3'd5, 2'd2, 2'd1, 3'd3});
    rd(12'h044, rv); chk("R12 status cleared", rv, 0);
    rd(12'h100, rv); chk("R12 busy", rv, 32'h80);
    wr(12'h00C, 32'h30EE0000);
    wr(12'h000, 32'h0);
    chk("R11 ignored launch", ph_opcode, 8'h9F);
    repeat (2) @(negedge clk);
    chk("R5 held", {ph_valid, ph_opcode}, {1'b1, 8'h9F});
    accept();
    chk("R5 accepted", ph_valid, 0);
    finish_phase(3'b000);
    rd(12'h044, rv); chk("R6 status ok", rv, 32'h8000);
    chk("R6 busy clear", busy, 0);
    chk("R8 done pulse type0", done_seen, 1);
  endtask

  task automatic t_type1_seq();
    wr(12'h004, 32'h00000001); wr(12'h00C, 32'h300B0000); wr(12'h010, 32'h0);
    wr(12'h000, 32'h0);
    accept();
    finish_phase(3'b000);
    chk("R7 armed busy", {busy, ph_valid}, 2'b10);
    rd(12'h044, rv); chk("R7 armed status", rv, 0);
    wr(12'h008, 32'h56780000); wr(12'h00C, 32'h00800012);
    wr(12'h010, 32'h00001310); wr(12'h004, 32'h0000007F);
    wr(12'h000, 32'h1);
    chk("R7 data valid", {ph_valid, ph_kind}, 2'b11);
    chk("R7 count", ph_count, 32'h00125678);
    chk("R7 fields", {ph_dummy, ph_dir, ph_dl, ph_bank}, {6'd8, 1'b1, 2'd3, 3'd1});
    accept();
    finish_phase(3'b000);
    rd(12'h044, rv); chk("R8 status ok", rv, 32'h8000);
    chk("R8 done pulse", done_seen, 1);
  endtask

  task automatic t_rejects();
    wr(12'h004, 32'h0000007F); wr(12'h000, 32'h0);
    rd(12'h044, rv); chk("R9 orphan descriptor", rv, 32'hC001);
    chk("R9 orphan idle", {busy, ph_valid}, 0);
    wr(12'h004, 32'h00000005); wr(12'h000, 32'h0);
    rd(12'h044, rv); chk("R9 undefined type", rv, 32'hC001);
    wr(12'h004, 32'h00000001); wr(12'h000, 32'h0);
    accept(); finish_phase(3'b000);
    wr(12'h004, 32'h0); wr(12'h000, 32'h0);
    rd(12'h044, rv); chk("R9 armed non-descriptor", rv, 32'hC001);
    chk("R9 armed idle", {busy, ph_valid}, 0);
  endtask

  task automatic t_errors();
    wr(12'h004, 32'h0); wr(12'h000, 32'h0);
    accept();
    finish_phase(3'b101);
    rd(12'h044, rv); chk("R10 error status", rv, 32'hC00A);
    chk("R8 no done pulse", done_seen, 0);
    chk("R10 busy clear", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_staging();
    t_mode_reject();
    t_type0();
    t_type1_seq();
    t_rejects();
    t_errors();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule